// File: doc/BRIEF.md
# SD Command and Response Unit

This unit sits between a register bus and a card-side request engine. Software builds a 32-bit command argument from two 16-bit writes and then writes a 16-bit command word. The unit hands the command index and argument to the card interface as a one-cycle request, waits for the reply, and judges that reply against the response kind encoded in the command word. Depending on that kind it raises completion, timeout, card-error or power-up-busy flags, and it keeps up to 128 bits of reply in eight 16-bit words.

The flags live in a write-one-to-clear status register. An interrupt line is high whenever any status flag is also enabled in a 15-bit enable register. A rising edge on the card-detect input raises its own status flag. The card reply arrives as a byte array with a byte count. Byte i is at bits 8i+7:8i of the reply bus.

Top module: `sd_cmd_unit`

## Requirements
- R1: Register addresses are 0 command word, 1 argument bits 15:0, 2 argument bits 31:16, 3 control (bit 11 = unit on), 4 status, 5 interrupt enable, and 8+i response word i. In the command word, bits 5:0 are the index, bit 7 is init, bits 10:8 are the response kind and bit 11 is busy. An accepted command drives its index on `card_cmd_idx`, and address 0 reads back the last accepted word.
- R2: A command write is ignored while the on bit is clear, and also while an earlier command is still waiting for its reply. No request is issued and the stored command word does not change.
- R3: A command with init set and index 0 sets only status bit 0 and never raises `card_req`.
- R4: An accepted command clears all eight response words. Unless it is the R3 case, it raises `card_req` for exactly one cycle, in the cycle after the write.
- R5: Kinds 1, 3 and 6 expect 4 reply bytes, and kind 2 expects 16. A shorter reply sets status bit 7 instead of bit 0 and stores nothing. Any other kind expects no bytes, sets bit 0 and stores nothing.
- R6: For kind 1, with or without the busy bit, the 4 reply bytes form a 32-bit word, byte 0 most significant. Status bit 14 is set if any of word bits 31:26, 24:19 or 16 is set, and is cleared otherwise.
- R7: For kind 3, status bit 12 is set when bit 7 of reply byte 0 is clear, and is cleared when that bit is set.
- R8: For kind 6, status bit 14 is set if reply bytes 2 and 3, taken as a 16-bit value ANDed with 0xE008, give a nonzero result, and is cleared otherwise.
- R9: Reply byte 2k (high half) and byte 2k+1 (low half) go to response word 7-k. Bytes beyond the expected length read as zero.
- R10: A completing command with index 12 sets status bits 0 and 2 together.
- R11: Writing the status register clears every bit written as 1. A flag set in the same cycle wins. The enable register keeps bits 14:0, and `irq` is high whenever status AND enable is nonzero.
- R12: A low-to-high change on `card_det` sets status bit 1. A high-to-low change sets nothing.
- R13: Writing the control register with the on bit clear zeroes the status register and abandons a command that is still waiting. A reply that arrives later has no effect.
- R14: Each argument half is written on its own and keeps the other half. `card_arg` always shows the full 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| card_req | output | 1 | One-cycle command request to the card side |
| card_cmd_idx | output | 6 | Command index of the request |
| card_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Reply present this cycle |
| card_rsp_len | input | 5 | Number of reply bytes |
| card_rsp_data | input | 128 | Reply bytes, byte i at bits 8i+7:8i |
| card_det | input | 1 | Card-detect level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a single register port, so a command write, a control write and a status write never fall in the same cycle. They also assume that `card_rsp_valid` is a single-cycle pulse given only after a request. The bench issues one write per cycle and answers every request with exactly one reply pulse. The only exception is the abandoned command of R13, which gets its late reply after the unit has been switched off and on again. The card-detect input changes only between clock edges, and it is held low through reset.

// File: rtl/sdcu_pkg.sv
package sdcu_pkg;
  localparam int WORD_W   = 16;
  localparam int ARG_W    = 32;
  localparam int NWORDS   = 8;
  localparam int NBYTES   = 2 * NWORDS;
  localparam int LEN_W    = $clog2(NBYTES) + 1;
  localparam int IDX_W    = 6;

  localparam int ST_END   = 0;
  localparam int ST_CDET  = 1;
  localparam int ST_STOP  = 2;
  localparam int ST_TMO   = 7;
  localparam int ST_OCRB  = 12;
  localparam int ST_CERR  = 14;

  localparam logic [31:0] CSTAT_ERR_MASK = 32'hFDF9_0000;
  localparam logic [15:0] RCA_ERR_MASK   = 16'hE008;

  localparam logic [2:0] KIND_STAT = 3'd1;
  localparam logic [2:0] KIND_LONG = 3'd2;
  localparam logic [2:0] KIND_OCR  = 3'd3;
  localparam logic [2:0] KIND_RCA  = 3'd6;

  function automatic logic [LEN_W-1:0] expect_len(input logic [2:0] kind);
    case (kind)
      KIND_STAT, KIND_OCR, KIND_RCA: expect_len = LEN_W'(4);
      KIND_LONG:                     expect_len = LEN_W'(NBYTES);
      default:                       expect_len = '0;
    endcase
  endfunction

  function automatic logic reply_has_error(input logic [2:0] kind, input logic [31:0] w);
    if (kind == KIND_STAT)     reply_has_error = |(w & CSTAT_ERR_MASK);
    else if (kind == KIND_RCA) reply_has_error = |(w[15:0] & RCA_ERR_MASK);
    else                       reply_has_error = 1'b0;
  endfunction

  // word k of the reply byte stream, bytes at or beyond n read as zero
  function automatic logic [WORD_W-1:0] reply_word(input logic [8*NBYTES-1:0] d,
                                                   input logic [LEN_W-1:0] n,
                                                   input int k);
    logic [7:0] hi, lo;
    hi = (2*k   < int'(n)) ? d[16*k +: 8]     : 8'h00;
    lo = (2*k+1 < int'(n)) ? d[16*k+8 +: 8]   : 8'h00;
    return {hi, lo};
  endfunction
endpackage

// File: rtl/sdcu_seq.sv
module sdcu_seq
  import sdcu_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_wr,
  input  logic                      enable,
  input  logic                      abort,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      rsp_valid,
  input  logic [LEN_W-1:0]          rsp_len,
  input  logic [8*NBYTES-1:0]       rsp_data,
  output logic                      req,
  output logic [WORD_W-1:0]         cmd_q,
  output logic                      init0,
  output logic                      ev_end,
  output logic                      ev_stop,
  output logic                      ev_timeout,
  output logic                      ev_err_upd,
  output logic                      ev_err_val,
  output logic                      ev_ocr_upd,
  output logic                      ev_ocr_val,
  output logic                      rsp_clear,
  output logic                      rsp_load,
  output logic [LEN_W-1:0]          rsp_keep
);
  logic        busy_q;
  logic        accept, done, short_rsp, good;
  logic [2:0]  kind;
  logic [31:0] head;

  assign accept    = cmd_wr & enable & ~busy_q;
  assign init0     = accept & wr_data[7] & (wr_data[5:0] == '0);
  assign kind      = cmd_q[10:8];
  assign rsp_keep  = expect_len(kind);
  assign done      = busy_q & rsp_valid & ~abort;
  assign short_rsp = rsp_len < rsp_keep;
  assign good      = done & ~short_rsp;
  assign head      = {rsp_data[7:0], rsp_data[15:8], rsp_data[23:16], rsp_data[31:24]};

  assign ev_end     = init0 | good;
  assign ev_stop    = good & (cmd_q[5:0] == 6'd12);
  assign ev_timeout = done & short_rsp;
  assign ev_err_upd = good & ((kind == KIND_STAT) | (kind == KIND_RCA));
  assign ev_err_val = reply_has_error(kind, head);
  assign ev_ocr_upd = good & (kind == KIND_OCR);
  assign ev_ocr_val = ~head[31];
  assign rsp_clear  = accept;
  assign rsp_load   = good & (rsp_keep != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req    <= 1'b0;
      cmd_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      req <= 1'b0;
      if (accept) begin
        cmd_q <= wr_data;
        if (!init0) begin
          busy_q <= 1'b1;
          req    <= 1'b1;
        end
      end else if (done) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdcu_rsp_store.sv
module sdcu_rsp_store
  import sdcu_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear,
  input  logic                              load,
  input  logic [LEN_W-1:0]                  keep,
  input  logic [8*NBYTES-1:0]               data,
  output logic [NWORDS-1:0][WORD_W-1:0]     words
);
  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n || clear) words[i] <= '0;
      else if (load)       words[i] <= reply_word(data, keep, NWORDS-1-i);
    end
  end
endmodule

// File: rtl/sdcu_status.sv
module sdcu_status
  import sdcu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_wr,
  input  logic               ien_wr,
  input  logic               wipe,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               ev_end,
  input  logic               ev_stop,
  input  logic               ev_timeout,
  input  logic               ev_err_upd,
  input  logic               ev_err_val,
  input  logic               ev_ocr_upd,
  input  logic               ev_ocr_val,
  input  logic               card_det,
  output logic               ev_cd_rise,
  output logic [WORD_W-1:0]  status,
  output logic [WORD_W-1:0]  ien,
  output logic               irq
);
  logic              det_q;
  logic [WORD_W-1:0] nxt;

  assign ev_cd_rise = card_det & ~det_q;

  always_comb begin
    nxt = status;
    if (stat_wr)    nxt = nxt & ~wr_data;
    if (ev_end)     nxt[ST_END]  = 1'b1;
    if (ev_cd_rise) nxt[ST_CDET] = 1'b1;
    if (ev_stop)    nxt[ST_STOP] = 1'b1;
    if (ev_timeout) nxt[ST_TMO]  = 1'b1;
    if (ev_ocr_upd) nxt[ST_OCRB] = ev_ocr_val;
    if (ev_err_upd) nxt[ST_CERR] = ev_err_val;
    if (wipe)       nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      ien    <= '0;
      det_q  <= 1'b0;
    end else begin
      status <= nxt;
      det_q  <= card_det;
      if (ien_wr) ien <= {1'b0, wr_data[WORD_W-2:0]};
    end
  end

  assign irq = |(status & ien);
endmodule

// File: rtl/sd_cmd_unit.sv
module sd_cmd_unit
  import sdcu_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [15:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [15:0]          rd_data,
  output logic                 card_req,
  output logic [5:0]           card_cmd_idx,
  output logic [31:0]          card_arg,
  input  logic                 card_rsp_valid,
  input  logic [4:0]           card_rsp_len,
  input  logic [127:0]         card_rsp_data,
  input  logic                 card_det,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ARGL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ARGH = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(5);
  localparam int               RSP_BASE = 8;
  localparam int               ON_BIT   = 11;

  logic cmd_wr, stat_wr, dis_wr, ien_wr, ctrl_wr;
  logic enable_q;
  logic [ARG_W-1:0] arg_q;
  logic [WORD_W-1:0] cmd_q, status, ien;
  logic init0, ev_end, ev_stop, ev_timeout, ev_err_upd, ev_err_val;
  logic ev_ocr_upd, ev_ocr_val, rsp_clear, rsp_load, ev_cd_rise;
  logic [LEN_W-1:0] rsp_keep;
  logic [NWORDS-1:0][WORD_W-1:0] words;

  assign cmd_wr  = wr_en & (wr_addr == A_CMD);
  assign ctrl_wr = wr_en & (wr_addr == A_CTRL);
  assign stat_wr = wr_en & (wr_addr == A_STAT);
  assign ien_wr  = wr_en & (wr_addr == A_IEN);
  assign dis_wr  = ctrl_wr & ~wr_data[ON_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      arg_q    <= '0;
    end else begin
      if (ctrl_wr) enable_q <= wr_data[ON_BIT];
      if (wr_en && wr_addr == A_ARGL) arg_q[15:0]  <= wr_data;
      if (wr_en && wr_addr == A_ARGH) arg_q[31:16] <= wr_data;
    end
  end

  sdcu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .enable(enable_q), .abort(dis_wr),
    .wr_data(wr_data), .rsp_valid(card_rsp_valid), .rsp_len(card_rsp_len),
    .rsp_data(card_rsp_data), .req(card_req), .cmd_q(cmd_q), .init0(init0),
    .ev_end(ev_end), .ev_stop(ev_stop), .ev_timeout(ev_timeout),
    .ev_err_upd(ev_err_upd), .ev_err_val(ev_err_val), .ev_ocr_upd(ev_ocr_upd),
    .ev_ocr_val(ev_ocr_val), .rsp_clear(rsp_clear), .rsp_load(rsp_load),
    .rsp_keep(rsp_keep)
  );

  sdcu_rsp_store u_rsp (
    .clk(clk), .rst_n(rst_n), .clear(rsp_clear), .load(rsp_load),
    .keep(rsp_keep), .data(card_rsp_data), .words(words)
  );

  sdcu_status u_stat (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .ien_wr(ien_wr), .wipe(dis_wr),
    .wr_data(wr_data), .ev_end(ev_end), .ev_stop(ev_stop), .ev_timeout(ev_timeout),
    .ev_err_upd(ev_err_upd), .ev_err_val(ev_err_val), .ev_ocr_upd(ev_ocr_upd),
    .ev_ocr_val(ev_ocr_val), .card_det(card_det), .ev_cd_rise(ev_cd_rise),
    .status(status), .ien(ien), .irq(irq)
  );

  assign card_cmd_idx = cmd_q[IDX_W-1:0];
  assign card_arg     = arg_q;

  always_comb begin
    case (rd_addr)
      A_CMD:   rd_data = cmd_q;
      A_ARGL:  rd_data = arg_q[15:0];
      A_ARGH:  rd_data = arg_q[31:16];
      A_CTRL:  rd_data = 16'(enable_q) << ON_BIT;
      A_STAT:  rd_data = status;
      A_IEN:   rd_data = ien;
      default: rd_data = (int'(rd_addr) >= RSP_BASE && int'(rd_addr) < RSP_BASE + NWORDS)
                         ? words[3'(int'(rd_addr) - RSP_BASE)] : '0;
    endcase
  end
endmodule

// File: rtl/sdcu_checker.sv
module sdcu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        enable,
  input logic        dis_wr,
  input logic        stat_wr,
  input logic [15:0] wr_data,
  input logic        card_req,
  input logic [15:0] status,
  input logic        init0,
  input logic        ev_end,
  input logic        ev_stop,
  input logic        ev_timeout,
  input logic        ev_cd_rise
);
  a_r2_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !enable) |=> !card_req);

  a_r3_init_local: assert property (@(posedge clk) disable iff (!rst_n)
    init0 |=> (!card_req && status[0]));

  a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |=> !card_req);

  a_r5_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timeout && !dis_wr) |=> status[7]);

  a_r10_stop_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !dis_wr) |=> (status[2] && status[0]));

  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wr_data[0] && !ev_end) |=> !status[0]);

  a_r12_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cd_rise && !dis_wr) |=> status[1]);

  a_r13_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> (status == 16'h0000));
endmodule

bind sd_cmd_unit sdcu_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .enable(enable_q), .dis_wr(dis_wr),
  .stat_wr(stat_wr), .wr_data(wr_data), .card_req(card_req), .status(status),
  .init0(init0), .ev_end(ev_end), .ev_stop(ev_stop), .ev_timeout(ev_timeout),
  .ev_cd_rise(ev_cd_rise)
);

// File: tb/test_sd_cmd_unit.sv
module test_sd_cmd_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [15:0]  rd_data;
  logic         card_req;
  logic [5:0]   card_cmd_idx;
  logic [31:0]  card_arg;
  logic         card_rsp_valid = 1'b0;
  logic [4:0]   card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;
  logic         card_det = 1'b0;
  logic         irq;

  int checks = 0;
  int errors = 0;

  sd_cmd_unit i_sd_cmd_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .card_req(card_req),
    .card_cmd_idx(card_cmd_idx), .card_arg(card_arg), .card_rsp_valid(card_rsp_valid),
    .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data), .card_det(card_det),
    .irq(irq)
  );

  always #10 clk = ~clk;

  // {command, length, first four bytes, status, word7, word6}
  localparam int NV = 10;
  localparam logic [103:0] VEC [NV] = '{
    {16'h0111, 8'd4,  32'h0000_0900, 16'h0001, 16'h0000, 16'h0900},
    {16'h0111, 8'd4,  32'h8000_0000, 16'h4001, 16'h8000, 16'h0000},
    {16'h090C, 8'd4,  32'h0000_0000, 16'h0005, 16'h0000, 16'h0000},
    {16'h0329, 8'd4,  32'h00FF_8000, 16'h1001, 16'h00FF, 16'h8000},
    {16'h0329, 8'd4,  32'h80FF_8000, 16'h0001, 16'h80FF, 16'h8000},
    {16'h0111, 8'd2,  32'h1234_0000, 16'h0080, 16'h0000, 16'h0000},
    {16'h0603, 8'd4,  32'h1234_E000, 16'h4001, 16'h1234, 16'hE000},
    {16'h0000, 8'd0,  32'h0000_0000, 16'h0001, 16'h0000, 16'h0000},
    {16'h0202, 8'd16, 32'h0000_0000, 16'h0001, 16'h1011, 16'h1213},
    {16'h0202, 8'd4,  32'h1122_3344, 16'h0080, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic reply(input logic [4:0] len, input logic [127:0] data);
    card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_data = data;
    @(negedge clk);
    card_rsp_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [127:0] bytes;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(4, v); check("R11 reset status", v, 16'h0);
    check("R11 reset irq", irq, 0);
    check("R4 reset card_req", card_req, 0);
    rd(15, v); check("R9 reset word7", v, 16'h0);

    // R14 argument halves
    wr(1, 16'h5678); wr(2, 16'h1234);
    check("R14 full arg", card_arg, 32'h1234_5678);
    wr(1, 16'hAAAA);
    check("R14 low write keeps high", card_arg, 32'h1234_AAAA);
    wr(2, 16'h0F0F);
    rd(1, v); check("R14 high write keeps low", v, 16'hAAAA);

    // R2 ignored while off
    wr(0, 16'h0111);
    check("R2 no request while off", card_req, 0);
    rd(0, v); check("R2 command not stored while off", v, 16'h0);

    wr(3, 16'h0800);

    for (int n = 0; n < NV; n++) begin
      logic [15:0] cmd, st, w7, w6;
      logic [7:0]  len;
      logic [31:0] d4;
      {cmd, len, d4, st, w7, w6} = VEC[n];
      bytes = '0;
      if (len == 8'd16) begin
        for (int b = 0; b < 16; b++) bytes[8*b +: 8] = 8'h10 + 8'(b);
      end else begin
        bytes[7:0] = d4[31:24]; bytes[15:8] = d4[23:16];
        bytes[23:16] = d4[15:8]; bytes[31:24] = d4[7:0];
      end
      wr(4, 16'hFFFF);
      wr(0, cmd);
      check("R4 request pulse", card_req, 1);
      check("R1 command index", card_cmd_idx, cmd[5:0]);
      reply(len[4:0], bytes);
      check("R4 request dropped", card_req, 0);
      rd(4, v); check("R5 R6 R7 R8 R10 status", v, st);
      rd(15, v); check("R9 word7", v, w7);
      rd(14, v); check("R9 word6", v, w6);
      rd(8, v); check("R9 word0", v, (len == 8'd16 && st[0]) ? 16'h1E1F : 16'h0000);
    end

    // R3 init with index 0; also R4 clear of response words
    wr(4, 16'hFFFF);
    wr(0, 16'h0080);
    check("R3 no request", card_req, 0);
    rd(4, v); check("R3 only end flag", v, 16'h0001);
    rd(15, v); check("R4 words cleared", v, 16'h0);
    rd(0, v); check("R1 last command readback", v, 16'h0080);

    // R2 ignored while waiting
    wr(0, 16'h0111);
    check("R4 request issued", card_req, 1);
    wr(0, 16'h0112);
    check("R2 no second request", card_req, 0);
    rd(0, v); check("R2 command kept while waiting", v, 16'h0111);
    reply(5'd4, 128'h0);

    // R11 interrupt enable and write-one-to-clear
    wr(4, 16'hFFFF);
    wr(5, 16'hFFFF);
    rd(5, v); check("R11 enable 15 bits", v, 16'h7FFF);
    wr(5, 16'h0000);
    wr(0, 16'h0080);
    check("R11 irq masked", irq, 0);
    wr(5, 16'h0001);
    check("R11 irq raised", irq, 1);
    wr(4, 16'h0002);
    rd(4, v); check("R11 other bits kept", v, 16'h0001);
    wr(4, 16'h0001);
    rd(4, v); check("R11 cleared", v, 16'h0000);
    check("R11 irq dropped", irq, 0);

    // R12 card detect
    @(negedge clk); card_det = 1'b1;
    @(negedge clk);
    rd(4, v); check("R12 rise sets bit1", v, 16'h0002);
    wr(4, 16'hFFFF);
    card_det = 1'b0;
    repeat (2) @(negedge clk);
    rd(4, v); check("R12 fall sets nothing", v, 16'h0000);

    // R13 disable wipes status and drops pending command
    @(negedge clk); card_det = 1'b1;
    wr(0, 16'h0111);
    rd(4, v); check("R12 bit1 before disable", v, 16'h0002);
    wr(3, 16'h0000);
    rd(4, v); check("R13 status zeroed", v, 16'h0000);
    wr(3, 16'h0800);
    reply(5'd4, 128'hFF);
    rd(4, v); check("R13 late reply ignored", v, 16'h0000);
    rd(15, v); check("R13 words untouched", v, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule